// File: doc/BRIEF.md
# MSI-X Vector Table and Pending Engine

This block keeps the per-vector message table and the pending-bit array of a message-signalled interrupt function, and turns interrupt requests from device logic into outbound message writes. Each vector owns a 64-bit target address, a 32-bit payload word and a mask bit. Software reaches the table and the pending array through a small register port using 4- or 8-byte little-endian accesses. Device logic raises one vector per request, and the block emits the selected vector's address and payload on an outbound valid/ready port.

A request is dropped if its vector has no users. If the vector is masked, either by its own mask bit or by the function-wide mask, the request is recorded as pending. Otherwise the message goes out. Any transition from masked to unmasked replays a pending message exactly once. This applies to a write to a vector's control word and to a rescan pulse from the capability logic, which samples the enable and mask-all controls. A rescan walks all vectors in ascending order and has priority over new requests and register accesses.

After reset, the block spends one cycle per vector clearing the table storage. During this time the register port and the request port are held off.

Top module: `msixv_engine`

## Requirements
- R1: After reset, and once the clearing walk ends, every vector reads address 0 and payload 0. Every control word reads 1 (masked). The pending array reads 0, and no message is offered.
- R2: Each vector occupies 16 bytes at byte offset 16*v. The address low word is at +0, the address high word at +4, the payload at +8 and the control word at +12. Only control bit 0 (mask) is stored, and the other control bits read 0. An 8-byte access at +0 covers {high,low}, and one at +8 covers {control,payload}. A read result appears on the read-valid output two cycles after the access is accepted.
- R3: A request on a used, unmasked vector emits that vector's {high,low} address and payload.
- R4: A request on a vector whose use count is zero has no effect: no message is sent and the pending bit stays clear.
- R5: A request on a masked vector sets its pending bit and sends nothing. The effective mask is the stored function mask OR the vector mask bit.
- R6: Pending bit v is bit v of the little-endian pending array (bit v mod 8 of byte v/8). The array spans a multiple of 64 bits, and bits at or above the vector count read 0. A 4-byte read at byte offset 4 returns bits 63:32.
- R7: A control-word write that unmasks a vector with its pending bit set clears the bit and sends that vector's message once, using the newly written table contents.
- R8: A write to the pending array changes nothing and raises the error output for exactly one cycle.
- R9: A use command increments the vector's use count. An unuse command decrements it, saturating at zero, and clears the pending bit when the count reaches zero.
- R10: A rescan pulse sets the function mask to (NOT enable) OR mask-all. If the function mask goes from masked to unmasked, every vector that is pending and not masked itself is replayed, with its pending bit cleared, in ascending vector order.
- R11: While a message is offered and not accepted, valid, address and payload hold steady.
- R12: From the cycle after a rescan pulse until the rescan walk finishes, neither request port nor register port is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_req | input | 1 | Register access request |
| reg_we | input | 1 | 1 for write, 0 for read |
| reg_pba | input | 1 | 1 selects the pending array, 0 selects the table |
| reg_wide | input | 1 | 1 for an 8-byte access, 0 for a 4-byte access |
| reg_addr | input | log2(NUM_VEC)+4 | Byte offset within the selected region |
| reg_wdata | input | 64 | Write data, little-endian |
| reg_ready | output | 1 | Register access accepted this cycle when requested |
| reg_rvalid | output | 1 | Read data valid (one cycle) |
| reg_rdata | output | 64 | Read data, zero-extended for 4-byte reads |
| pba_wr_err | output | 1 | One-cycle flag for a write to the pending array |
| irq_req | input | 1 | Interrupt request |
| irq_vec | input | log2(NUM_VEC) | Requested vector |
| irq_ready | output | 1 | Request accepted this cycle when raised |
| cnt_valid | input | 1 | Use-count command strobe |
| cnt_use | input | 1 | 1 increments (use), 0 decrements (unuse) |
| cnt_vec | input | log2(NUM_VEC) | Vector for the use-count command |
| fn_enable | input | 1 | Function enable, sampled on rescan |
| fn_maskall | input | 1 | Function mask-all, sampled on rescan |
| rescan | input | 1 | Rescan pulse from the capability logic |
| msg_valid | output | 1 | Outbound message valid |
| msg_ready | input | 1 | Outbound message accepted |
| msg_addr | output | 64 | Message target address |
| msg_data | output | 32 | Message payload |

## Verification
The hardest case to reach is the function-level replay. It needs several vectors that are individually unmasked, in use and pending, all at once, while the function mask is set, followed by a request that arrives just as the rescan walk starts. The stimulus first sets mask-all through a rescan. It then unmasks chosen vectors with control writes that cannot yet fire, parks requests on them as pending, and issues a new request immediately after the unmasking rescan. The bench then expects the replays in ascending order, with the late request behind them. A use count that is driven below zero and then incremented once shows saturation: the next masked request must become pending rather than disappear.

// File: rtl/msixv_pkg.sv
package msixv_pkg;
  typedef enum logic [2:0] {
    S_INIT,
    S_IDLE,
    S_FETCH,
    S_LOAD,
    S_EMIT,
    S_RRESP,
    S_SCAN
  } state_t;

  localparam int DW_LANES = 3;  // address low, address high, payload
endpackage

// File: rtl/msixv_table_ram.sv
module msixv_table_ram #(
  parameter int N     = 16,
  parameter int VW    = 4,
  parameter int LANES = 3
) (
  input  logic                   clk,
  input  logic [LANES-1:0]       we,
  input  logic [VW-1:0]          waddr,
  input  logic [LANES-1:0][31:0] wdata,
  input  logic [VW-1:0]          raddr,
  output logic [LANES-1:0][31:0] rdata
);
  // One simple dual-port dword memory per lane, registered read.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [31:0] mem [N];
    logic [31:0] rq;
    always_ff @(posedge clk) begin
      if (we[g]) mem[waddr] <= wdata[g];
      rq <= mem[raddr];
    end
    assign rdata[g] = rq;
  end
endmodule

// File: rtl/msixv_use_ctr.sv
module msixv_use_ctr #(
  parameter int N  = 16,
  parameter int VW = 4,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic          cmd_use,
  input  logic [VW-1:0] cmd_vec,
  output logic [N-1:0]  used,
  output logic [N-1:0]  drain
);
  localparam logic [CW-1:0] CMAX = '1;

  for (genvar g = 0; g < N; g++) begin : g_cnt
    logic [CW-1:0] cnt;
    logic          hit;
    assign hit = cmd_valid && (cmd_vec == VW'(g));
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt <= '0;
      end else if (hit) begin
        if (cmd_use) begin
          if (cnt != CMAX) cnt <= cnt + 1'b1;
        end else if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end
      end
    end
    assign used[g]  = (cnt != '0);
    assign drain[g] = hit && !cmd_use && (cnt == CW'(1));
  end
endmodule

// File: rtl/msixv_rd_mux.sv
module msixv_rd_mux #(
  parameter int N     = 16,
  parameter int OFF_W = 8,
  parameter int PBA_Q = 1
) (
  input  logic             is_pba,
  input  logic             wide,
  input  logic [OFF_W-1:0] addr,
  input  logic [2:0][31:0] lanes,
  input  logic             mask_bit,
  input  logic [N-1:0]     pend,
  output logic [63:0]      rdata
);
  localparam int PBA_BITS = PBA_Q * 64;

  logic [31:0]         dw_arr [4];
  logic [PBA_BITS-1:0] padded;
  logic [63:0]         qword;
  logic                unused_lsb;

  assign unused_lsb = ^addr[1:0];

  always_comb begin
    dw_arr[0] = lanes[0];
    dw_arr[1] = lanes[1];
    dw_arr[2] = lanes[2];
    dw_arr[3] = {31'b0, mask_bit};
    padded = '0;
    padded[N-1:0] = pend;
    qword = '0;
    for (int q = 0; q < PBA_Q; q++) begin
      if (int'(addr[OFF_W-1:3]) == q) qword = padded[q*64 +: 64];
    end
    if (is_pba) begin
      if (wide) rdata = qword;
      else      rdata = {32'b0, addr[2] ? qword[63:32] : qword[31:0]};
    end else begin
      if (wide) rdata = {dw_arr[{addr[3], 1'b1}], dw_arr[{addr[3], 1'b0}]};
      else      rdata = {32'b0, dw_arr[addr[3:2]]};
    end
  end
endmodule

// File: rtl/msixv_engine.sv
module msixv_engine
  import msixv_pkg::*;
#(
  parameter int NUM_VEC = 16,
  parameter int CNT_W   = 4,
  localparam int VW     = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
  localparam int OFF_W  = VW + 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_req,
  input  logic             reg_we,
  input  logic             reg_pba,
  input  logic             reg_wide,
  input  logic [OFF_W-1:0] reg_addr,
  input  logic [63:0]      reg_wdata,
  output logic             reg_ready,
  output logic             reg_rvalid,
  output logic [63:0]      reg_rdata,
  output logic             pba_wr_err,
  input  logic             irq_req,
  input  logic [VW-1:0]    irq_vec,
  output logic             irq_ready,
  input  logic             cnt_valid,
  input  logic             cnt_use,
  input  logic [VW-1:0]    cnt_vec,
  input  logic             fn_enable,
  input  logic             fn_maskall,
  input  logic             rescan,
  output logic             msg_valid,
  input  logic             msg_ready,
  output logic [63:0]      msg_addr,
  output logic [31:0]      msg_data
);
  localparam int             PBA_Q = (NUM_VEC + 63) / 64;
  localparam logic [VW-1:0]  LAST  = VW'(NUM_VEC - 1);

  state_t             st;
  logic [VW-1:0]      init_idx, idx, op_vec;
  logic [OFF_W-1:0]   op_addr;
  logic               op_wide, op_pba, ret_scan;
  logic               fm_q, old_fm, rescan_pend;
  logic [NUM_VEC-1:0] mask_q, pend_q, pend_nxt, used, drain;

  // Register-port decode
  logic [VW-1:0]           reg_vec;
  logic [1:0]              reg_dw;
  logic                    reg_go, irq_go, tbl_wr, ctrl_wr;
  logic [3:0]              lane_hit;
  logic [31:0]             ctrl_wd;
  logic                    mask_new, was_m, now_m, unmask_hit;
  logic                    irq_masked, scan_hit;
  logic [DW_LANES-1:0]     ram_we;
  logic [VW-1:0]           ram_waddr, ram_raddr;
  logic [DW_LANES-1:0][31:0] ram_wd, ram_rd;
  logic [63:0]             rd_word;
  logic                    unused_bits;

  assign reg_ready = (st == S_IDLE) && !rescan_pend;
  assign irq_ready = reg_ready && !reg_req;
  assign reg_go    = reg_req && reg_ready;
  assign irq_go    = irq_req && irq_ready;

  assign reg_vec = reg_addr[OFF_W-1:4];
  assign reg_dw  = reg_addr[3:2];
  assign tbl_wr  = reg_go && reg_we && !reg_pba;
  assign ctrl_wd = reg_wide ? reg_wdata[63:32] : reg_wdata[31:0];
  assign unused_bits = ^{reg_addr[1:0], ctrl_wd[31:1]};

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      lane_hit[k] = reg_wide ? (k[1] == reg_dw[1]) : (k[1:0] == reg_dw);
    end
  end

  assign ctrl_wr    = tbl_wr && lane_hit[3];
  assign mask_new   = ctrl_wr ? ctrl_wd[0] : mask_q[reg_vec];
  assign was_m      = fm_q | mask_q[reg_vec];
  assign now_m      = fm_q | mask_new;
  assign unmask_hit = tbl_wr && was_m && !now_m && pend_q[reg_vec];
  assign irq_masked = fm_q | mask_q[irq_vec];
  assign scan_hit   = old_fm && !fm_q && !mask_q[idx] && pend_q[idx];

  // Table storage ports
  always_comb begin
    ram_waddr = (st == S_INIT) ? init_idx : reg_vec;
    for (int k = 0; k < DW_LANES; k++) begin
      if (st == S_INIT) begin
        ram_we[k] = 1'b1;
        ram_wd[k] = '0;
      end else begin
        ram_we[k] = tbl_wr && lane_hit[k];
        ram_wd[k] = (reg_wide && k[0]) ? reg_wdata[63:32] : reg_wdata[31:0];
      end
    end
    case (st)
      S_IDLE:  ram_raddr = reg_go ? reg_vec : irq_vec;
      S_SCAN:  ram_raddr = idx;
      default: ram_raddr = op_vec;
    endcase
  end

  msixv_table_ram #(.N(NUM_VEC), .VW(VW), .LANES(DW_LANES)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wd),
    .raddr (ram_raddr),
    .rdata (ram_rd)
  );

  msixv_use_ctr #(.N(NUM_VEC), .VW(VW), .CW(CNT_W)) u_use (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cnt_valid),
    .cmd_use   (cnt_use),
    .cmd_vec   (cnt_vec),
    .used      (used),
    .drain     (drain)
  );

  msixv_rd_mux #(.N(NUM_VEC), .OFF_W(OFF_W), .PBA_Q(PBA_Q)) u_mux (
    .is_pba   (op_pba),
    .wide     (op_wide),
    .addr     (op_addr),
    .lanes    (ram_rd),
    .mask_bit (mask_q[op_vec]),
    .pend     (pend_q),
    .rdata    (rd_word)
  );

  // Pending array next state: set on masked request, clear on replay,
  // clear when the use count drains (last so it wins).
  always_comb begin
    pend_nxt = pend_q;
    if (st == S_IDLE && irq_go && used[irq_vec] && irq_masked)
      pend_nxt[irq_vec] = 1'b1;
    if (unmask_hit)
      pend_nxt[reg_vec] = 1'b0;
    if (st == S_SCAN && scan_hit)
      pend_nxt[idx] = 1'b0;
    pend_nxt = pend_nxt & ~drain;
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_nxt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= S_INIT;
      init_idx    <= '0;
      idx         <= '0;
      op_vec      <= '0;
      op_addr     <= '0;
      op_wide     <= 1'b0;
      op_pba      <= 1'b0;
      ret_scan    <= 1'b0;
      mask_q      <= '1;
      fm_q        <= 1'b1;
      old_fm      <= 1'b1;
      rescan_pend <= 1'b0;
      msg_valid   <= 1'b0;
      msg_addr    <= '0;
      msg_data    <= '0;
      reg_rvalid  <= 1'b0;
      reg_rdata   <= '0;
      pba_wr_err  <= 1'b0;
    end else begin
      reg_rvalid <= 1'b0;
      pba_wr_err <= 1'b0;
      case (st)
        S_INIT: begin
          init_idx <= init_idx + 1'b1;
          if (init_idx == LAST) st <= S_IDLE;
        end
        S_IDLE: begin
          if (rescan_pend) begin
            rescan_pend <= 1'b0;
            old_fm      <= fm_q;
            fm_q        <= !fn_enable || fn_maskall;
            if (fm_q && fn_enable && !fn_maskall) begin
              idx <= '0;
              st  <= S_SCAN;
            end
          end else if (reg_go) begin
            op_vec  <= reg_vec;
            op_addr <= reg_addr;
            op_wide <= reg_wide;
            op_pba  <= reg_pba;
            if (!reg_we) begin
              st <= S_RRESP;
            end else if (reg_pba) begin
              pba_wr_err <= 1'b1;
            end else begin
              if (ctrl_wr) mask_q[reg_vec] <= ctrl_wd[0];
              if (unmask_hit) begin
                ret_scan <= 1'b0;
                st       <= S_FETCH;
              end
            end
          end else if (irq_go && used[irq_vec] && !irq_masked) begin
            op_vec   <= irq_vec;
            ret_scan <= 1'b0;
            st       <= S_LOAD;
          end
        end
        S_FETCH: st <= S_LOAD;
        S_LOAD: begin
          msg_addr  <= {ram_rd[1], ram_rd[0]};
          msg_data  <= ram_rd[2];
          msg_valid <= 1'b1;
          st        <= S_EMIT;
        end
        S_EMIT: begin
          if (msg_ready) begin
            msg_valid <= 1'b0;
            if (ret_scan && idx != LAST) begin
              idx <= idx + 1'b1;
              st  <= S_SCAN;
            end else begin
              st <= S_IDLE;
            end
          end
        end
        S_RRESP: begin
          reg_rdata  <= rd_word;
          reg_rvalid <= 1'b1;
          st         <= S_IDLE;
        end
        S_SCAN: begin
          if (scan_hit) begin
            op_vec   <= idx;
            ret_scan <= 1'b1;
            st       <= S_LOAD;
          end else if (idx == LAST) begin
            st <= S_IDLE;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
      if (rescan) rescan_pend <= 1'b1;
    end
  end
endmodule

// File: rtl/msixv_chk.sv
module msixv_chk #(
  parameter int N = 16
) (
  input logic        clk,
  input logic        rst,
  input logic        reg_req,
  input logic        reg_ready,
  input logic        reg_we,
  input logic        reg_pba,
  input logic        reg_rvalid,
  input logic        pba_wr_err,
  input logic        irq_ready,
  input logic        rescan,
  input logic        msg_valid,
  input logic        msg_ready,
  input logic [63:0] msg_addr,
  input logic [31:0] msg_data,
  input logic [N-1:0] pend_q,
  input logic [N-1:0] used
);
  // R1: the cycle after reset nothing is offered and the port is held off
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!msg_valid && !reg_ready));

  // R2: read data valid two cycles after an accepted read
  p_read_latency_r2: assert property (@(posedge clk) disable iff (rst)
    reg_rvalid |-> $past(reg_req && reg_ready && !reg_we, 2));

  // R8: error flag only after an accepted pending-array write
  p_pba_err_r8: assert property (@(posedge clk) disable iff (rst)
    pba_wr_err |-> $past(reg_req && reg_ready && reg_we && reg_pba));

  // R9: a pending bit never survives on a vector with no users
  p_pend_used_r9: assert property (@(posedge clk) disable iff (rst)
    (pend_q & ~used) == '0);

  // R11: an offered message holds until taken
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

  // R12: a rescan pulse blocks both request ports on the next cycle
  p_rescan_first_r12: assert property (@(posedge clk) disable iff (rst)
    $past(rescan) |-> (!irq_ready && !reg_ready));
endmodule

bind msixv_engine msixv_chk #(.N(NUM_VEC)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_req    (reg_req),
  .reg_ready  (reg_ready),
  .reg_we     (reg_we),
  .reg_pba    (reg_pba),
  .reg_rvalid (reg_rvalid),
  .pba_wr_err (pba_wr_err),
  .irq_ready  (irq_ready),
  .rescan     (rescan),
  .msg_valid  (msg_valid),
  .msg_ready  (msg_ready),
  .msg_addr   (msg_addr),
  .msg_data   (msg_data),
  .pend_q     (pend_q),
  .used       (used)
);

// File: tb/msixv_engine_tb.sv
module msixv_engine_tb;
  localparam int N   = 16;
  localparam int VW  = 4;
  localparam int OFF = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic           rst, reg_req, reg_we, reg_pba, reg_wide;
  logic [OFF-1:0] reg_addr;
  logic [63:0]    reg_wdata, reg_rdata;
  logic           reg_ready, reg_rvalid, pba_wr_err;
  logic           irq_req, irq_ready, cnt_valid, cnt_use;
  logic [VW-1:0]  irq_vec, cnt_vec;
  logic           fn_enable, fn_maskall, rescan;
  logic           msg_valid, msg_ready;
  logic [63:0]    msg_addr;
  logic [31:0]    msg_data;

  msixv_engine #(.NUM_VEC(N), .CNT_W(4)) u_dut (.*);

  int checks = 0, errors = 0, err_pulses = 0;
  bit done = 0;
  logic [63:0] got_a[$];
  logic [31:0] got_d[$];

  always @(negedge clk) begin
    if (!rst) begin
      if (msg_valid && msg_ready) begin
        got_a.push_back(msg_addr);
        got_d.push_back(msg_data);
      end
      if (pba_wr_err) err_pulses++;
    end
  end

  function automatic logic [31:0] exp_lo(int v);   return 32'hFEE0_0000 + 32'(v * 16); endfunction
  function automatic logic [31:0] exp_hi(int v);   return 32'h0000_0100 + 32'(v);      endfunction
  function automatic logic [31:0] exp_data(int v); return 32'h0000_4000 + 32'(v * 3);  endfunction

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic reg_op(input bit we, input bit pba, input bit wide, input int a,
                        input logic [63:0] wd, output logic [63:0] rd);
    @(negedge clk);
    while (!reg_ready) @(negedge clk);
    reg_req = 1; reg_we = we; reg_pba = pba; reg_wide = wide;
    reg_addr = OFF'(a); reg_wdata = wd;
    @(negedge clk);
    reg_req = 0; reg_we = 0;
    rd = '0;
    if (!we) begin
      while (!reg_rvalid) @(negedge clk);
      rd = reg_rdata;
    end
  endtask

  task automatic wr(input bit pba, input bit wide, input int a, input logic [63:0] wd);
    logic [63:0] d;
    reg_op(1, pba, wide, a, wd, d);
  endtask

  task automatic rd(input bit pba, input bit wide, input int a, output logic [63:0] d);
    reg_op(0, pba, wide, a, '0, d);
  endtask

  task automatic irq(input int v);
    @(negedge clk);
    while (!irq_ready) @(negedge clk);
    irq_req = 1; irq_vec = VW'(v);
    @(negedge clk);
    irq_req = 0;
  endtask

  task automatic cmd(input bit use_it, input int v);
    @(negedge clk);
    cnt_valid = 1; cnt_use = use_it; cnt_vec = VW'(v);
    @(negedge clk);
    cnt_valid = 0;
  endtask

  task automatic do_rescan(input bit en, input bit mk);
    @(negedge clk);
    fn_enable = en; fn_maskall = mk; rescan = 1;
    @(negedge clk);
    rescan = 0;
    chk("R12", "irq_ready after rescan", 64'(irq_ready), 64'd0);
  endtask

  task automatic settle();
    repeat (3 * N + 20) @(negedge clk);
  endtask

  task automatic expect_msg(input string req, input int v);
    int w = 0;
    while (got_a.size() == 0 && w < 400) begin @(negedge clk); w++; end
    if (got_a.size() == 0) begin
      chk(req, $sformatf("message for vector %0d", v), 64'd0, {exp_hi(v), exp_lo(v)});
    end else begin
      chk(req, $sformatf("msg addr v%0d", v), got_a.pop_front(), {exp_hi(v), exp_lo(v)});
      chk(req, $sformatf("msg data v%0d", v), 64'(got_d.pop_front()), 64'(exp_data(v)));
    end
  endtask

  task automatic expect_none(input string req);
    settle();
    chk(req, "no message", 64'(got_a.size()), 64'd0);
    got_a.delete(); got_d.delete();
  endtask

  task automatic pba_is(input string req, input logic [63:0] exp);
    logic [63:0] d;
    rd(1, 1, 0, d);
    chk(req, "pending qword", d, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog (R1..all): got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] d, a0;
    logic [31:0] d0;
    rst = 1; reg_req = 0; reg_we = 0; reg_pba = 0; reg_wide = 0; reg_addr = '0;
    reg_wdata = '0; irq_req = 0; irq_vec = '0; cnt_valid = 0; cnt_use = 0;
    cnt_vec = '0; fn_enable = 0; fn_maskall = 0; rescan = 0; msg_ready = 1;
    repeat (5) @(negedge clk);
    rst = 0;
    while (!reg_ready) @(negedge clk);
    chk("R1", "msg_valid after reset", 64'(msg_valid), 64'd0);

    // R1: cleared table, all masked, nothing pending
    for (int v = 0; v < N; v++)
      for (int k = 0; k < 4; k++) begin
        rd(0, 0, v * 16 + k * 4, d);
        chk("R1", $sformatf("v%0d dword %0d", v, k), d, (k == 3) ? 64'd1 : 64'd0);
      end
    pba_is("R1", 64'd0);

    // R2: program with mixed access widths, read back wide
    for (int v = 0; v < N; v++) begin
      if (v % 2 == 0) wr(0, 1, v * 16, {exp_hi(v), exp_lo(v)});
      else begin
        wr(0, 0, v * 16, 64'(exp_lo(v)));
        wr(0, 0, v * 16 + 4, 64'(exp_hi(v)));
      end
      wr(0, 0, v * 16 + 8, 64'(exp_data(v)));
    end
    for (int v = 0; v < N; v++) begin
      rd(0, 1, v * 16, d);
      chk("R2", $sformatf("wide addr v%0d", v), d, {exp_hi(v), exp_lo(v)});
      rd(0, 1, v * 16 + 8, d);
      chk("R2", $sformatf("wide ctrl/data v%0d", v), d, {32'd1, exp_data(v)});
    end

    do_rescan(1, 0);
    expect_none("R10");

    // R4: unused vector ignores requests
    irq(3);
    expect_none("R4");
    pba_is("R4", 64'd0);

    // R5/R6: masked requests become pending at bit v
    for (int v = 0; v < N; v++) cmd(1, v);
    irq(3); irq(9); irq(15);
    expect_none("R5");
    rd(1, 0, 0, d); chk("R6", "pending low dword", d, 64'h8208);
    rd(1, 0, 4, d); chk("R6", "pending high dword", d, 64'd0);
    pba_is("R6", 64'h8208);

    // R7 (and R2 reserved bits): unmask with pending replays once
    wr(0, 0, 3 * 16 + 12, 64'hFFFF_FFFE);
    expect_msg("R7", 3);
    expect_none("R7");
    rd(0, 0, 3 * 16 + 12, d); chk("R2", "ctrl reserved bits", d, 64'd0);
    pba_is("R7", 64'h8200);

    // R3/R11: unmasked request, held under backpressure
    msg_ready = 0;
    irq(3);
    while (!msg_valid) @(negedge clk);
    a0 = msg_addr; d0 = msg_data;
    repeat (5) @(negedge clk);
    chk("R11", "valid held", 64'(msg_valid), 64'd1);
    chk("R11", "addr held", msg_addr, a0);
    chk("R11", "data held", 64'(msg_data), 64'(d0));
    msg_ready = 1;
    expect_msg("R3", 3);

    // R8: pending array writes ignored, one error pulse
    wr(1, 1, 0, '1);
    repeat (4) @(negedge clk);
    chk("R8", "error pulses", 64'(err_pulses), 64'd1);
    pba_is("R8", 64'h8200);

    // R9: drain clears pending; unuse saturates at zero
    cmd(0, 9);
    pba_is("R9", 64'h8000);
    cmd(0, 9); cmd(1, 9);
    irq(9);
    expect_none("R9");
    pba_is("R9", 64'h8200);

    // R10/R12: function-level replay ordering with a late request
    do_rescan(1, 1);
    wr(0, 0, 5 * 16 + 12, 64'd0);
    wr(0, 0, 9 * 16 + 12, 64'd0);
    wr(0, 0, 15 * 16 + 12, 64'd0);
    irq(5);
    expect_none("R10");
    pba_is("R10", 64'h8220);
    do_rescan(1, 0);
    irq(3);
    expect_msg("R10", 5);
    expect_msg("R10", 9);
    expect_msg("R10", 15);
    expect_msg("R12", 3);
    pba_is("R10", 64'd0);

    // R5: function disable masks every vector
    do_rescan(0, 0);
    irq(3);
    expect_none("R5");
    pba_is("R5", 64'h0008);
    do_rescan(1, 0);
    expect_msg("R10", 3);

    // R3: sweep every vector unmasked
    for (int v = 0; v < N; v++) wr(0, 0, v * 16 + 12, 64'd0);
    expect_none("R7");
    for (int v = 0; v < N; v++) begin
      irq(v);
      expect_msg("R3", v);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule